// File: doc/BRIEF.md
# Prescaled Baud Tick Generator

This block produces the bit-rate timing for one UART channel. The input clock first passes through a power-of-two prescaler whose exponent comes from a 4-bit select register; its output is the basic clock. An 8-bit reload counter divides the basic clock by a programmable count, and a final divide-by-two stage yields the baud rate. The output is a strobe one input-clock cycle wide, which the serial shifters use as a clock enable.

Software programs the generator through a small byte-wide write port. Any write to one of the three configuration offsets restarts the whole divider chain from zero. It also drops a ready output, which the surrounding logic uses to keep transmit and receive disabled until two basic clocks have passed. A clock-enable bit in the mode register holds the entire generator idle while it is clear. Out-of-range settings are forced into the legal range rather than rejected.

Top module: `baud_gen`

## Requirements
- R1: After reset the mode enable is clear, the prescale select is 0 and the count is 8. With the generator idle, `baudTick` and `ready` are both 0. Setting only the enable then gives the timing of select 0 and count 8.
- R2: While bit 7 of the mode register is 0, `baudTick` and `ready` stay 0, whatever the other mode bits hold.
- R3: With an effective select n and an effective count C, the first `baudTick` pulse comes in cycle index 2^(n+1)*C-1 after the last configuration write edge. Index 0 is the cycle that directly follows that edge. Later pulses repeat every 2^(n+1)*C cycles, and each pulse is one cycle wide.
- R4: A select value above 11 acts as 11.
- R5: A count value below 8 acts as 8.
- R6: A write to a configuration offset restarts the prescaler, the reload counter and the divide-by-two stage from zero. A write in the middle of a period therefore realigns the pulse timing to that write.
- R7: After a configuration write, `ready` is 0 for exactly 2^(n+1) cycles (two basic clocks) and then stays 1 until the next configuration write or disable.
- R8: Writes to offsets other than 0, 6 and 7 have no effect on the pulse timing or on `ready`.
- R9: The write offsets are: 0 for the mode register, whose enable is bit 7; 6 for the select, which takes bits 3:0; and 7 for the count, which takes bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register offset |
| wrData | input | 8 | Write data |
| baudTick | output | 1 | One-cycle baud-rate strobe |
| ready | output | 1 | High once settling after the last configuration write is over |

## Verification
A wrong internal state shows at the ports as a shift in pulse timing. A prescaler or reload counter that does not restart on a write moves the first pulse away from index 2^(n+1)*C-1. A missing divide-by-two stage halves the pulse spacing, and this shows up within the first period. A settle counter that counts input cycles instead of basic clocks, or that is not cleared, moves the rise of `ready` visibly whenever the select is non-zero. A faulty clamp or an address decode that accepts foreign offsets changes the spacing measured in the next period.

// File: rtl/baud_gen_pkg.sv
package baud_gen_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic hold;     // generator disabled
    logic restart;  // configuration write this cycle
  } dpStrobe_t;

endpackage

// File: rtl/baud_gen_ctrl.sv
module baud_gen_ctrl
  import baud_gen_pkg::*;
#(
  parameter int SEL_W        = 4,
  parameter int MAX_SEL      = 11,
  parameter int CNT_W        = 8,
  parameter int MIN_CNT      = 8,
  parameter int ADDR_W       = 3,
  parameter int MODE_OFS     = 0,
  parameter int SEL_OFS      = 6,
  parameter int CNT_OFS      = 7,
  parameter int EN_BIT       = 7,
  parameter int SETTLE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  wrData,
  input  logic              basicTick,
  output dpStrobe_t         strobe,
  output logic [SEL_W-1:0]  effSel,
  output logic [CNT_W-1:0]  reload,
  output logic              modeEn,
  output logic              ready
);

  localparam int SET_W = $clog2(SETTLE_TICKS + 1);
  localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_OFS);
  localparam logic [ADDR_W-1:0] SEL_A  = ADDR_W'(SEL_OFS);
  localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(CNT_OFS);

  logic [SEL_W-1:0] selReg;
  logic [CNT_W-1:0] cntReg;
  logic [SET_W-1:0] settleCnt;
  logic             modeHit, selHit, cntHit, cfgWrite;

  assign modeHit  = regWrEn && (regAddr == MODE_A);
  assign selHit   = regWrEn && (regAddr == SEL_A);
  assign cntHit   = regWrEn && (regAddr == CNT_A);
  assign cfgWrite = modeHit || selHit || cntHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeEn <= 1'b0;
      selReg <= '0;
      cntReg <= CNT_W'(MIN_CNT);
    end else begin
      if (modeHit) modeEn <= wrData[EN_BIT];
      if (selHit)  selReg <= wrData[SEL_W-1:0];
      if (cntHit)  cntReg <= wrData;
    end
  end

  // Range forcing
  always_comb begin
    effSel = (selReg > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : selReg;
    reload = (cntReg < CNT_W'(MIN_CNT)) ? CNT_W'(MIN_CNT) : cntReg;
  end

  assign strobe.hold    = !modeEn;
  assign strobe.restart = cfgWrite;

  // Settling: count basic clocks since restart, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      settleCnt <= '0;
    end else if (strobe.hold || strobe.restart) begin
      settleCnt <= '0;
    end else if (basicTick && (settleCnt != SET_W'(SETTLE_TICKS))) begin
      settleCnt <= settleCnt + SET_W'(1);
    end
  end

  assign ready = modeEn && (settleCnt == SET_W'(SETTLE_TICKS));

endmodule

// File: rtl/baud_gen_datapath.sv
module baud_gen_datapath
  import baud_gen_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int MAX_SEL = 11,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strobe,
  input  logic [SEL_W-1:0] effSel,
  input  logic [CNT_W-1:0] reload,
  output logic             basicTick,
  output logic             baudTick
);

  localparam int PRE_W = (MAX_SEL > 0) ? MAX_SEL : 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic [CNT_W-1:0] divCnt;
  logic [CNT_W-1:0] termVal;
  logic             halfPhase;
  logic             halfWrap;
  logic             clearAll;

  assign clearAll = strobe.hold || strobe.restart;

  // Prescaler: basic tick when the low n bits are all ones
  assign preMask   = ~({PRE_W{1'b1}} << effSel);
  assign basicTick = !strobe.hold && ((preCnt & preMask) == preMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         preCnt <= '0;
    else if (clearAll) preCnt <= '0;
    else               preCnt <= preCnt + PRE_W'(1);
  end

  // Reload counter over basic ticks
  assign termVal  = reload - CNT_W'(1);
  assign halfWrap = basicTick && (divCnt == termVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt    <= '0;
      halfPhase <= 1'b0;
    end else if (clearAll) begin
      divCnt    <= '0;
      halfPhase <= 1'b0;
    end else if (basicTick) begin
      if (halfWrap) begin
        divCnt    <= '0;
        halfPhase <= !halfPhase;
      end else begin
        divCnt <= divCnt + CNT_W'(1);
      end
    end
  end

  // Final divide-by-two: pulse on every second wrap
  assign baudTick = halfWrap && halfPhase;

endmodule

// File: rtl/baud_gen.sv
module baud_gen
  import baud_gen_pkg::*;
#(
  parameter int SEL_W        = 4,
  parameter int MAX_SEL      = 11,
  parameter int CNT_W        = 8,
  parameter int MIN_CNT      = 8,
  parameter int ADDR_W       = 3,
  parameter int MODE_OFS     = 0,
  parameter int SEL_OFS      = 6,
  parameter int CNT_OFS      = 7,
  parameter int EN_BIT       = 7,
  parameter int SETTLE_TICKS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CNT_W-1:0]  wrData,
  output logic              baudTick,
  output logic              ready
);

  dpStrobe_t        strobe;
  logic [SEL_W-1:0] effSel;
  logic [CNT_W-1:0] reload;
  logic             basicTick;
  logic             modeEn;

  baud_gen_ctrl #(
    .SEL_W(SEL_W), .MAX_SEL(MAX_SEL), .CNT_W(CNT_W), .MIN_CNT(MIN_CNT),
    .ADDR_W(ADDR_W), .MODE_OFS(MODE_OFS), .SEL_OFS(SEL_OFS),
    .CNT_OFS(CNT_OFS), .EN_BIT(EN_BIT), .SETTLE_TICKS(SETTLE_TICKS)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .wrData(wrData), .basicTick(basicTick), .strobe(strobe),
    .effSel(effSel), .reload(reload), .modeEn(modeEn), .ready(ready)
  );

  baud_gen_datapath #(
    .SEL_W(SEL_W), .MAX_SEL(MAX_SEL), .CNT_W(CNT_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .effSel(effSel),
    .reload(reload), .basicTick(basicTick), .baudTick(baudTick)
  );

endmodule

// File: rtl/baud_gen_checker.sv
module baud_gen_checker #(
  parameter int ADDR_W   = 3,
  parameter int MODE_OFS = 0,
  parameter int SEL_OFS  = 6,
  parameter int CNT_OFS  = 7
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic              baudTick,
  input logic              ready,
  input logic              modeEn
);

  logic cfgHit;
  assign cfgHit = regWrEn && (regAddr == ADDR_W'(MODE_OFS) ||
                              regAddr == ADDR_W'(SEL_OFS) ||
                              regAddr == ADDR_W'(CNT_OFS));

  p_idle_when_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    !modeEn |-> (!baudTick && !ready));

  p_tick_one_cycle_r3: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |=> !baudTick);

  p_write_drops_ready_r6: assert property (@(posedge clk) disable iff (!rstN)
    cfgHit |=> !ready);

  p_tick_after_settle_r7: assert property (@(posedge clk) disable iff (!rstN)
    baudTick |-> ready);

  p_ready_holds_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !cfgHit) |=> ready);

endmodule

bind baud_gen baud_gen_checker #(
  .ADDR_W(ADDR_W), .MODE_OFS(MODE_OFS), .SEL_OFS(SEL_OFS), .CNT_OFS(CNT_OFS)
) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .baudTick(baudTick), .ready(ready), .modeEn(modeEn)
);

// File: tb/baud_gen_tb_top.sv
module baud_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 6;

  // {select[47:44], count[43:36], first tick index[35:16], ready rise index[15:0]}
  localparam logic [47:0] VEC_TABLE [NUM_VEC] = '{
    {4'd0,  8'd8,   20'd15,    16'd2},
    {4'd1,  8'd8,   20'd31,    16'd4},
    {4'd3,  8'd10,  20'd159,   16'd16},
    {4'd2,  8'd3,   20'd63,    16'd8},
    {4'd15, 8'd8,   20'd32767, 16'd4096},
    {4'd4,  8'd7,   20'd255,   16'd32}
  };

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic       baudTick;
  logic       ready;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_gen dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .wrData(wrData), .baudTick(baudTick), .ready(ready)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Ends at a falling edge inside cycle index 0 after the write edge
  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; wrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic measure(input int expFirst, input int expReady, input string tag);
    int t1 = -1;
    int t2 = -1;
    int rk = -1;
    bit wide = 1'b0;
    bit prev = 1'b0;
    for (int k = 0; k <= 2*expFirst + 4; k++) begin
      if (ready && rk < 0) rk = k;
      if (baudTick) begin
        if (prev) wide = 1'b1;
        if (t1 < 0) t1 = k;
        else if (t2 < 0) t2 = k;
      end
      prev = baudTick;
      @(negedge clk);
    end
    check(t1 == expFirst, {tag, " R3 first tick"}, t1, expFirst);
    check((t2 - t1) == expFirst + 1, {tag, " R3 period"}, t2 - t1, expFirst + 1);
    check(!wide, {tag, " R3 one-cycle pulse"}, int'(wide), 0);
    check(rk == expReady, {tag, " R7 ready rise"}, rk, expReady);
  endtask

  // Count cycles between two pulses with foreign writes in between
  task automatic foreignWrites();
    int gap = 0;
    bit lostReady = 1'b0;
    while (!baudTick) @(negedge clk);
    @(negedge clk); gap = 1;
    repeat (3) begin @(negedge clk); gap++; end
    regWrEn = 1'b1; regAddr = 3'd3; wrData = 8'h00; @(negedge clk); gap++;
    regAddr = 3'd5; wrData = 8'hFF; @(negedge clk); gap++;
    regAddr = 3'd1; wrData = 8'h80; @(negedge clk); gap++;
    regWrEn = 1'b0;
    while (!baudTick) begin
      if (!ready) lostReady = 1'b1;
      @(negedge clk); gap++;
    end
    check(gap == 16, "R8 spacing after foreign writes", gap, 16);
    check(!lostReady, "R8 ready kept", int'(lostReady), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int ticks;
    int readyHigh;
    repeat (3) @(negedge clk);
    check(!baudTick && !ready, "R1 outputs in reset", int'(baudTick | ready), 0);
    rstN = 1'b1;
    ticks = 0; readyHigh = 0;
    repeat (40) begin
      @(negedge clk);
      ticks += int'(baudTick); readyHigh += int'(ready);
    end
    check(ticks == 0 && readyHigh == 0, "R1 idle after reset", ticks + readyHigh, 0);

    // Enable only: reset defaults select 0, count 8
    wrReg(3'd0, 8'h80);
    measure(15, 2, "R1 defaults");

    // Table walk
    for (int i = 0; i < NUM_VEC; i++) begin
      logic [3:0] s;
      logic [7:0] c;
      string tag;
      s = VEC_TABLE[i][47:44];
      c = VEC_TABLE[i][43:36];
      tag = (s > 4'd11) ? "R4 clamp" : (c < 8'd8) ? "R5 floor" : "R9 offsets";
      wrReg(3'd6, {4'h0, s});
      wrReg(3'd7, c);
      measure(int'(VEC_TABLE[i][35:16]), int'(VEC_TABLE[i][15:0]), tag);
    end

    // Upper select bits ignored (R9): 0xF1 selects 1
    wrReg(3'd6, 8'hF1);
    wrReg(3'd7, 8'd8);
    measure(31, 4, "R9 select field");

    // Restart mid-period
    wrReg(3'd6, 8'h00);
    wrReg(3'd7, 8'd8);
    while (!baudTick) @(negedge clk);
    repeat (6) @(negedge clk);
    wrReg(3'd7, 8'd8);
    measure(15, 2, "R6 restart");

    // Foreign offsets
    foreignWrites();

    // Disable with other mode bits set
    wrReg(3'd0, 8'h7F);
    ticks = 0; readyHigh = 0;
    repeat (200) begin
      ticks += int'(baudTick); readyHigh += int'(ready);
      @(negedge clk);
    end
    check(ticks == 0, "R2 no pulses while off", ticks, 0);
    check(readyHigh == 0, "R2 ready low while off", readyHigh, 0);

    // Re-enable resumes
    wrReg(3'd0, 8'h80);
    measure(15, 2, "R2 re-enable");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule